// File: doc/BRIEF.md
# Inter-Core Send Command Dispatcher

This block takes 64-bit send commands that any core issues and carries them out on the register file of the core that the command names. There are three kinds of command. An interrupt send raises one pending-interrupt bit on the target. A mailbox send stores a 32-bit word into one of eight mailbox words on the target. A register send stores a 32-bit word at any 16-bit register offset on the target. Both stores can preserve chosen bytes of the old word. In that case the block reads the old word first and merges it with the new data before it writes.

A valid/ready handshake accepts commands one at a time, so each read-merge-write completes before the next command starts. The core register files lie outside the block. The block reaches them through one shared request port that carries a core select, an operation, an offset and write data. A separate response channel returns read data, a completion strobe and an error flag. When a command is dropped or aborted, the block raises a one-cycle error strobe together with a cause code.

Top module: `ipi_send_dispatch`

## Requirements
- R1: After reset, cmd_ready is 1 and req_valid and err_valid are 0.
- R2: Command bits 25:16 name the target core for every command kind. If that number is not below NUM_CORES, the block issues no register request and pulses err_valid with err_cause 1.
- R3: An interrupt send (cmd_kind 0) issues exactly one request with req_op 2 (set bits) and no read. Its write data has only bit N set, where N is command bits 4:0.
- R4: A mailbox send (cmd_kind 1) targets offset 0x20 + 4*I, where I is command bits 4:2. Command bits 1:0 have no effect.
- R5: The 32-bit data word is command bits 63:32. When command bits 30:27 are all zero, the block issues no read and writes the data word unchanged with a single write (req_op 1).
- R6: When command bits 30:27 are nonzero, the block first reads the target word (req_op 0) and then writes one word. In that word, byte k keeps its old value when command bit 27+k is 1 and takes byte k of the data word otherwise.
- R7: A register send (cmd_kind 2) targets the offset in command bits 15:0 and applies the same byte-keep rule as R5 and R6.
- R8: If the read response carries rsp_err, the block issues no write and pulses err_valid with err_cause 2.
- R9: cmd_ready drops in the cycle after a command is accepted and stays low until that command is finished, so only one command is in flight at a time.
- R10: err_valid is high for exactly one cycle for each dropped or aborted command.
- R11: cmd_kind 3 is reserved. The block drops such a command without any register request and pulses err_valid with err_cause 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Dispatcher idle and able to take a command |
| cmd_kind | input | 2 | 0 interrupt, 1 mailbox, 2 register, 3 reserved |
| cmd_data | input | 64 | Command word |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request taken |
| req_op | output | 2 | 0 read, 1 write word, 2 OR bits into pending status |
| req_core | output | CIDX_W | Target core index |
| req_addr | output | 16 | Register offset on the target |
| req_wdata | output | 32 | Write data or bits to set |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_err | input | 1 | Response reports failure |
| rsp_rdata | input | 32 | Read data |
| err_valid | output | 1 | One-cycle error strobe |
| err_cause | output | 2 | 1 bad core, 2 read failure, 3 reserved kind |

## Verification
A sequencer stuck in a busy state holds cmd_ready low, and the next command never finishes. A wrongly decoded field or merge lane shows up in the target's stored word or pending bits, one response after the write is issued. A bad byte-keep test shows up as an extra read, or a missing one, in the same command. A lost error path shows up as a missing or stretched err_valid pulse in the cycle after the command is accepted or after the failed read returns.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;

    localparam int CMD_W      = 64;
    localparam int WORD_W     = 32;
    localparam int OFFS_W     = 16;
    localparam int CORE_FLD_W = 10;
    localparam int KEEP_W     = WORD_W / 8;
    localparam int VEC_W      = $clog2(WORD_W);

    localparam int CORE_LSB   = 16;
    localparam int KEEP_LSB   = 27;
    localparam int DATA_LSB   = 32;
    localparam int MBOX_LSB   = 2;
    localparam int MBOX_W     = 3;

    localparam logic [OFFS_W-1:0] MBOX_BASE  = 16'h0020;
    localparam logic [OFFS_W-1:0] STATUS_OFF = 16'h0000;

    typedef enum logic [1:0] {
        K_IPI  = 2'd0,
        K_MAIL = 2'd1,
        K_ANY  = 2'd2,
        K_RSVD = 2'd3
    } send_kind_e;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_SETBIT = 2'd2
    } reg_op_e;

    typedef enum logic [1:0] {
        E_NONE    = 2'd0,
        E_BADCORE = 2'd1,
        E_RDFAIL  = 2'd2,
        E_BADKIND = 2'd3
    } err_cause_e;

    typedef struct packed {
        send_kind_e              kind;
        logic [CORE_FLD_W-1:0]   core;
        logic [OFFS_W-1:0]       offs;
        logic [WORD_W-1:0]       data;
        logic [KEEP_W-1:0]       keep;
    } send_cmd_t;

    function automatic logic [OFFS_W-1:0] mbox_offset(input logic [MBOX_W-1:0] idx);
        return MBOX_BASE + OFFS_W'({idx, 2'b00});
    endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [1:0]       kind_i,
    input  logic [CMD_W-1:0] data_i,
    output send_cmd_t        cmd_o,
    output logic             core_ok_o,
    output logic             kind_ok_o
);
    logic [CORE_FLD_W-1:0] core_fld;
    logic [VEC_W-1:0]      vec_fld;

    assign core_fld  = data_i[CORE_LSB +: CORE_FLD_W];
    assign vec_fld   = data_i[VEC_W-1:0];
    assign core_ok_o = (32'(core_fld) < NUM_CORES);
    assign kind_ok_o = (kind_i != K_RSVD);

    always_comb begin
        cmd_o.kind = send_kind_e'(kind_i);
        cmd_o.core = core_fld;
        cmd_o.offs = STATUS_OFF;
        cmd_o.data = data_i[DATA_LSB +: WORD_W];
        cmd_o.keep = data_i[KEEP_LSB +: KEEP_W];
        case (send_kind_e'(kind_i))
            K_IPI: begin
                cmd_o.data = WORD_W'(1) << vec_fld;
                cmd_o.keep = '0;
            end
            K_MAIL: cmd_o.offs = mbox_offset(data_i[MBOX_LSB +: MBOX_W]);
            K_ANY:  cmd_o.offs = data_i[OFFS_W-1:0];
            default: cmd_o.keep = '0;
        endcase
    end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
    import ipi_disp_pkg::*;
#(
    parameter int LANES = KEEP_W
) (
    input  logic [LANES*8-1:0] old_i,
    input  logic [LANES*8-1:0] new_i,
    input  logic [LANES-1:0]   keep_i,
    output logic [LANES*8-1:0] word_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*8 +: 8] = keep_i[g] ? old_i[g*8 +: 8] : new_i[g*8 +: 8];
    end
endmodule

// File: rtl/ipi_disp_seq.sv
module ipi_disp_seq
    import ipi_disp_pkg::*;
#(
    parameter int CIDX_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  send_cmd_t          dec_cmd,
    input  logic               dec_core_ok,
    input  logic               dec_kind_ok,
    output send_cmd_t          cur_cmd,
    input  logic [WORD_W-1:0]  merged_word,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [1:0]         req_op,
    output logic [CIDX_W-1:0]  req_core,
    output logic [OFFS_W-1:0]  req_addr,
    output logic [WORD_W-1:0]  req_wdata,
    input  logic               rsp_valid,
    input  logic               rsp_err,
    output logic               err_valid,
    output logic [1:0]         err_cause
);
    typedef enum logic [2:0] {
        S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_ERR
    } seq_state_e;

    seq_state_e        st;
    send_cmd_t         cmd_q;
    logic [WORD_W-1:0] wdata_q;
    err_cause_e        cause_q;

    assign cur_cmd = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cmd_q   <= '0;
            wdata_q <= '0;
            cause_q <= E_NONE;
        end else begin
            case (st)
                S_IDLE: if (cmd_valid) begin
                    cmd_q   <= dec_cmd;
                    wdata_q <= dec_cmd.data;
                    if (!dec_kind_ok) begin
                        cause_q <= E_BADKIND;
                        st      <= S_ERR;
                    end else if (!dec_core_ok) begin
                        cause_q <= E_BADCORE;
                        st      <= S_ERR;
                    end else if (dec_cmd.keep != '0) begin
                        st <= S_RD_REQ;
                    end else begin
                        st <= S_WR_REQ;
                    end
                end
                S_RD_REQ: if (req_ready) st <= S_RD_WAIT;
                S_RD_WAIT: if (rsp_valid) begin
                    if (rsp_err) begin
                        cause_q <= E_RDFAIL;
                        st      <= S_ERR;
                    end else begin
                        wdata_q <= merged_word;
                        st      <= S_WR_REQ;
                    end
                end
                S_WR_REQ:  if (req_ready) st <= S_WR_WAIT;
                S_WR_WAIT: if (rsp_valid) st <= S_IDLE;
                default:   st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_ready = (st == S_IDLE);
        req_valid = (st == S_RD_REQ) || (st == S_WR_REQ);
        req_core  = cmd_q.core[CIDX_W-1:0];
        req_addr  = cmd_q.offs;
        req_wdata = (st == S_WR_REQ) ? wdata_q : '0;
        if (st == S_RD_REQ)          req_op = OP_READ;
        else if (cmd_q.kind == K_IPI) req_op = OP_SETBIT;
        else                          req_op = OP_WRITE;
        err_valid = (st == S_ERR);
        err_cause = (st == S_ERR) ? cause_q : E_NONE;
    end
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_kind,
    input  logic [63:0]       cmd_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_op,
    output logic [CIDX_W-1:0] req_core,
    output logic [15:0]       req_addr,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [31:0]       rsp_rdata,
    output logic              err_valid,
    output logic [1:0]        err_cause
);
    send_cmd_t         dec_cmd;
    send_cmd_t         cur_cmd;
    logic              core_ok;
    logic              kind_ok;
    logic [WORD_W-1:0] merged;

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .kind_i    (cmd_kind),
        .data_i    (cmd_data),
        .cmd_o     (dec_cmd),
        .core_ok_o (core_ok),
        .kind_ok_o (kind_ok)
    );

    ipi_byte_merge #(.LANES(KEEP_W)) u_merge (
        .old_i  (rsp_rdata),
        .new_i  (cur_cmd.data),
        .keep_i (cur_cmd.keep),
        .word_o (merged)
    );

    ipi_disp_seq #(.CIDX_W(CIDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .dec_cmd     (dec_cmd),
        .dec_core_ok (core_ok),
        .dec_kind_ok (kind_ok),
        .cur_cmd     (cur_cmd),
        .merged_word (merged),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_core    (req_core),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .err_valid   (err_valid),
        .err_cause   (err_cause)
    );
endmodule

// File: rtl/ipi_send_dispatch_chk.sv
module ipi_send_dispatch_chk #(
    parameter int NUM_CORES = 4,
    localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [63:0]       cmd_data,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [CIDX_W-1:0] req_core,
    input logic [15:0]       req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              err_valid,
    input logic [1:0]        err_cause
);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r9_req_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !cmd_ready);

    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_core)));

    a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    a_r3_single_set_bit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |-> ($countones(req_wdata) == 1));

    a_r2_badcore_right_after_accept: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_cause == 2'd1) |-> $past(cmd_valid && cmd_ready));

    a_r10_err_cause_nonzero: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_cause != 2'd0));

    a_r1_no_req_with_err: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !req_valid);
endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/tb_ipi_send_dispatch.sv
module tb_ipi_send_dispatch;
    localparam int NC = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_kind = 2'd0;
    logic [63:0]   cmd_data = '0;
    logic          req_valid;
    logic          req_ready = 1'b1;
    logic [1:0]    req_op;
    logic [CW-1:0] req_core;
    logic [15:0]   req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid = 1'b0;
    logic          rsp_err = 1'b0;
    logic [31:0]   rsp_rdata = '0;
    logic          err_valid;
    logic [1:0]    err_cause;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ipi_send_dispatch #(.NUM_CORES(NC)) dut (.*);

    // Register file model of the cores
    logic [31:0] mem [NC][64];
    logic [31:0] status [NC];
    logic        fail_rd = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          err_cnt = 0;
    logic [1:0]  last_cause = '0;

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        rsp_err   <= 1'b0;
        if (!rst && req_valid && req_ready) begin
            rsp_valid <= 1'b1;
            case (req_op)
                2'd0: begin
                    rd_cnt    <= rd_cnt + 1;
                    rsp_rdata <= mem[req_core][req_addr[7:2]];
                    rsp_err   <= fail_rd;
                end
                2'd1: begin
                    wr_cnt <= wr_cnt + 1;
                    mem[req_core][req_addr[7:2]] <= req_wdata;
                end
                default: begin
                    wr_cnt <= wr_cnt + 1;
                    status[req_core] <= status[req_core] | req_wdata;
                end
            endcase
        end
        if (!rst && err_valid) begin
            err_cnt    <= err_cnt + 1;
            last_cause <= err_cause;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [31:0] dat, input logic [3:0] keep,
                                       input logic [9:0] core, input logic [15:0] low);
        logic [63:0] w;
        w = '0;
        w[63:32] = dat;
        w[30:27] = keep;
        w[25:16] = core;
        w[15:0]  = low;
        return w;
    endfunction

    // Send one command, verify busy window, wait for completion
    task automatic send(input logic [1:0] kind, input logic [63:0] data);
        int t;
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk);
        cmd_kind  = kind;
        cmd_data  = data;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R9 busy after accept", 64'(cmd_ready), 64'd0);
        t = 0;
        while (!cmd_ready && t < 100) begin
            @(negedge clk);
            t++;
        end
        check(cmd_ready == 1'b1, "R9 completes", 64'(cmd_ready), 64'd1);
    endtask

    task automatic t_reset;
        check(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
        check(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);
        check(err_valid == 1'b0, "R1 err_valid", 64'(err_valid), 64'd0);
    endtask

    task automatic t_ipi;
        send(2'd0, mk(32'hFFFF_FFFF, 4'hF, 10'd2, 16'h0007));
        check(status[2] == 32'h80, "R3 vector 7 on core 2", 64'(status[2]), 64'h80);
        check(status[0] == 0 && status[1] == 0 && status[3] == 0, "R2 other cores untouched",
              64'(status[0] | status[1] | status[3]), 64'd0);
        check(rd_cnt == 0 && wr_cnt == 1, "R3 one set request no read", 64'(rd_cnt*16+wr_cnt), 64'd1);
        send(2'd0, mk(32'h0, 4'h0, 10'd3, 16'h001F));
        send(2'd0, mk(32'h0, 4'h0, 10'd3, 16'hFFE0));
        check(status[3] == 32'h8000_0001, "R3 vectors 31 and 0", 64'(status[3]), 64'h8000_0001);
    endtask

    task automatic t_mail_plain;
        send(2'd1, mk(32'hDEAD_BEEF, 4'h0, 10'd1, 16'h0017));
        check(mem[1][13] == 32'hDEAD_BEEF, "R4 R5 mailbox 5 full write", 64'(mem[1][13]), 64'hDEAD_BEEF);
        check(rd_cnt == 0 && wr_cnt == 1, "R5 no read when mask zero", 64'(rd_cnt*16+wr_cnt), 64'd1);
        send(2'd1, mk(32'h0BAD_CAFE, 4'h0, 10'd0, 16'h001C));
        check(mem[0][15] == 32'h0BAD_CAFE, "R4 mailbox 7", 64'(mem[0][15]), 64'h0BAD_CAFE);
    endtask

    task automatic t_mail_keep;
        send(2'd1, mk(32'h1122_3344, 4'b0101, 10'd1, 16'h0014));
        check(mem[1][13] == 32'h11AD_33EF, "R6 keep bytes 0 and 2", 64'(mem[1][13]), 64'h11AD_33EF);
        check(rd_cnt == 1 && wr_cnt == 1, "R6 read then write", 64'(rd_cnt*16+wr_cnt), 64'h11);
        send(2'd1, mk(32'h5555_5555, 4'b1111, 10'd1, 16'h0014));
        check(mem[1][13] == 32'h11AD_33EF, "R6 keep all bytes", 64'(mem[1][13]), 64'h11AD_33EF);
    endtask

    task automatic t_any;
        send(2'd2, mk(32'hCAFE_F00D, 4'h0, 10'd3, 16'h0084));
        check(mem[3][33] == 32'hCAFE_F00D, "R7 offset 0x84 full write", 64'(mem[3][33]), 64'hCAFE_F00D);
        send(2'd2, mk(32'h0102_0304, 4'b1000, 10'd3, 16'h0084));
        check(mem[3][33] == 32'hCA02_0304, "R7 keep byte 3", 64'(mem[3][33]), 64'hCA02_0304);
        check(rd_cnt == 1, "R7 merge reads", 64'(rd_cnt), 64'd1);
    endtask

    task automatic t_errors;
        int e0;
        e0 = err_cnt;
        send(2'd2, mk(32'h1, 4'h0, 10'd4, 16'h0084));
        check(err_cnt == e0 + 1 && last_cause == 2'd1, "R2 R10 core 4 rejected",
              64'(last_cause), 64'd1);
        check(rd_cnt + wr_cnt == 0, "R2 no request", 64'(rd_cnt + wr_cnt), 64'd0);
        send(2'd0, mk(32'h0, 4'h0, 10'd1023, 16'h0001));
        check(err_cnt == e0 + 2 && rd_cnt + wr_cnt == 0, "R2 core 1023 rejected",
              64'(err_cnt - e0), 64'd2);
        fail_rd = 1'b1;
        send(2'd1, mk(32'h9999_9999, 4'b0001, 10'd1, 16'h0014));
        fail_rd = 1'b0;
        check(last_cause == 2'd2 && err_cnt == e0 + 3, "R8 read failure cause", 64'(last_cause), 64'd2);
        check(wr_cnt == 0 && mem[1][13] == 32'h11AD_33EF, "R8 write aborted",
              64'(mem[1][13]), 64'h11AD_33EF);
        send(2'd3, mk(32'h7, 4'h0, 10'd0, 16'h0020));
        check(last_cause == 2'd3 && err_cnt == e0 + 4, "R11 reserved kind", 64'(last_cause), 64'd3);
        check(rd_cnt + wr_cnt == 0 && mem[0][8] == 32'h0, "R11 no request", 64'(mem[0][8]), 64'd0);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            status[c] = '0;
            for (int w = 0; w < 64; w++) mem[c][w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ipi();
        t_mail_plain();
        t_mail_keep();
        t_any();
        t_errors();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule